// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a multi-cycle processor datapath, and it is built as a microprogram rather than a hardwired state machine. A micro-address register selects one word of a fixed microcode store. Each word holds encoded fields. A decoder expands those fields into the individual datapath strobes and multiplexer selects, so the datapath sees the same control pins that a hardwired controller would drive.

The next micro-address comes from the sequencing field of the current word. That field can restart at the fetch word, step to the following word, or branch through one of two opcode-indexed dispatch tables. The first table is used after decode and separates instruction classes. The second table is used after the memory-address step and separates loads from stores.

The block has no data stream, so every pin is a plain control or status pin with no handshake. The opcode input must hold the opcode field of the instruction register. It is sampled only on the clock edge that leaves a dispatch word.

Top module: `ucode_sequencer`

## Requirements
- R1: A synchronous active-high reset, applied at any point in an instruction, forces the micro-address to 0. While the micro-address is 0, the outputs show the fetch controls.
- R2: A sequencing code of 00 loads micro-address 0 on the next edge, and code 11 loads the current micro-address plus one. The fetch word (0), the load-read word (3) and the R-type execute word (6) step sequentially. Words 4, 5, 7, 8 and 9 return to 0.
- R3: Word 0 asserts mem_rd, ir_we and pc_we. It sets mem_addr_data=0, pc_src=00, alu_op=00 (add), alu_a_sel=0 (PC) and alu_b_sel=01 (constant 4). All other enables are low.
- R4: Word 1 sets alu_op=00, alu_a_sel=0 and alu_b_sel=11 (shifted immediate), with no enable asserted. It then dispatches through table 1: opcode 000000 goes to 6, 000010 to 9, 000100 to 8, and 100011 or 101011 to 2.
- R5: Word 2 sets alu_op=00, alu_a_sel=1 and alu_b_sel=10 (sign-extended immediate). It then dispatches through table 2: 100011 goes to 3 and 101011 goes to 5. Only the opcode present during the dispatching cycle matters.
- R6: An opcode absent from a dispatch table sends the sequencer to micro-address 0.
- R7: The load path works as follows. Word 3 asserts mem_rd with mem_addr_data=1. Word 4 asserts rf_we with rf_dst_rd=0 and rf_wdata_mem=1.
- R8: The store word 5 asserts mem_wr with mem_addr_data=1 and no other enable.
- R9: Word 6 sets alu_op=10 (function code), alu_a_sel=1 and alu_b_sel=00. Word 7 asserts rf_we with rf_dst_rd=1 and rf_wdata_mem=0.
- R10: The branch word 8 sets alu_op=01 (subtract), alu_a_sel=1 and alu_b_sel=00. It asserts pc_we_zero with pc_src=01.
- R11: The jump word 9 asserts pc_we with pc_src=10.
- R12: A field that holds all zeros causes no action. Every enable driven by that field stays low, and its selects (mem_addr_data, rf_dst_rd, rf_wdata_mem, pc_src) read 0.
- R13: mem_rd and mem_wr are never high together. pc_we and pc_we_zero are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| uaddr | output | 4 | Current micro-address |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function code |
| alu_a_sel | output | 1 | ALU first operand: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU second operand: 00 B, 01 four, 10 extended immediate, 11 shifted immediate |
| rf_we | output | 1 | Register file write enable |
| rf_dst_rd | output | 1 | Destination register: 1 rd field, 0 rt field |
| rf_wdata_mem | output | 1 | Register write data: 1 memory data register, 0 ALU result register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr_data | output | 1 | Memory address: 0 PC, 1 ALU result register |
| ir_we | output | 1 | Instruction register load |
| pc_we | output | 1 | Unconditional PC write |
| pc_we_zero | output | 1 | PC write when the ALU zero flag is set |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target |

## Verification
The bench builds the block with its default widths: a 6-bit opcode and a 4-bit micro-address. At those widths the whole opcode space of 64 values is small enough to sweep. Every opcode is held through one complete instruction from reset. The expected path and the expected control word at each step are computed from the sequencing rules. This covers every dispatch entry, every fall-through to fetch for unlisted opcodes, and all ten microinstructions. Directed cases add an opcode change between the two dispatch points and a reset applied in the middle of an instruction.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'b00,
    ALU_SUB  = 2'b01,
    ALU_FUNC = 2'b10
  } alu_f_e;

  typedef enum logic [1:0] {
    OPB_REG  = 2'b00,
    OPB_FOUR = 2'b01,
    OPB_EXT  = 2'b10,
    OPB_SHF  = 2'b11
  } srcb_f_e;

  typedef enum logic [2:0] {
    RF_NONE  = 3'd0,
    RF_READ  = 3'd1,
    RF_WRALU = 3'd2,
    RF_WRMDR = 3'd3
  } rf_f_e;

  typedef enum logic [2:0] {
    MF_NONE  = 3'd0,
    MF_RDPC  = 3'd1,
    MF_RDALU = 3'd2,
    MF_WRALU = 3'd3
  } mem_f_e;

  typedef enum logic [3:0] {
    PF_NONE = 4'd0,
    PF_ALU  = 4'd1,
    PF_COND = 4'd2,
    PF_JMP  = 4'd3
  } pcw_f_e;

  typedef enum logic [1:0] {
    SQ_FETCH = 2'b00,
    SQ_DISP1 = 2'b01,
    SQ_DISP2 = 2'b10,
    SQ_NEXT  = 2'b11
  } seq_f_e;

  // 17-bit horizontal microinstruction
  typedef struct packed {
    alu_f_e  alu;
    logic    src1;
    srcb_f_e src2;
    rf_f_e   rfc;
    mem_f_e  mem;
    pcw_f_e  pcw;
    seq_f_e  seq;
  } uword_t;

  localparam int UWORD_W = $bits(uword_t);

  // opcode values used by the dispatch tables
  localparam logic [5:0] OPC_RTYPE = 6'b000000;
  localparam logic [5:0] OPC_JMP   = 6'b000010;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;

  // micro-addresses of the microprogram words
  localparam int UA_FETCH = 0;
  localparam int UA_DEC   = 1;
  localparam int UA_MADR  = 2;
  localparam int UA_LDRD  = 3;
  localparam int UA_LDWB  = 4;
  localparam int UA_STWR  = 5;
  localparam int UA_REX   = 6;
  localparam int UA_RWB   = 7;
  localparam int UA_BR    = 8;
  localparam int UA_JMP   = 9;

endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int UAW = 4
) (
  input  logic [UAW-1:0] addr,
  output uword_t         word
);

  always_comb begin
    word = '0;
    case (int'(addr))
      UA_FETCH: begin
        word.alu  = ALU_ADD;
        word.src1 = 1'b0;
        word.src2 = OPB_FOUR;
        word.mem  = MF_RDPC;
        word.pcw  = PF_ALU;
        word.seq  = SQ_NEXT;
      end
      UA_DEC: begin
        word.alu  = ALU_ADD;
        word.src1 = 1'b0;
        word.src2 = OPB_SHF;
        word.rfc  = RF_READ;
        word.seq  = SQ_DISP1;
      end
      UA_MADR: begin
        word.alu  = ALU_ADD;
        word.src1 = 1'b1;
        word.src2 = OPB_EXT;
        word.seq  = SQ_DISP2;
      end
      UA_LDRD: begin
        word.mem = MF_RDALU;
        word.seq = SQ_NEXT;
      end
      UA_LDWB: begin
        word.rfc = RF_WRMDR;
        word.seq = SQ_FETCH;
      end
      UA_STWR: begin
        word.mem = MF_WRALU;
        word.seq = SQ_FETCH;
      end
      UA_REX: begin
        word.alu  = ALU_FUNC;
        word.src1 = 1'b1;
        word.src2 = OPB_REG;
        word.seq  = SQ_NEXT;
      end
      UA_RWB: begin
        word.rfc = RF_WRALU;
        word.seq = SQ_FETCH;
      end
      UA_BR: begin
        word.alu  = ALU_SUB;
        word.src1 = 1'b1;
        word.src2 = OPB_REG;
        word.pcw  = PF_COND;
        word.seq  = SQ_FETCH;
      end
      UA_JMP: begin
        word.pcw = PF_JMP;
        word.seq = SQ_FETCH;
      end
      default: word = '0;
    endcase
  end

endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int OPW = 6,
  parameter int UAW = 4,
  parameter int TBL = 1
) (
  input  logic [OPW-1:0] op,
  output logic [UAW-1:0] target
);

  generate
    if (TBL == 1) begin : g_class
      always_comb begin
        target = '0;
        if      (op == OPW'(OPC_RTYPE)) target = UAW'(UA_REX);
        else if (op == OPW'(OPC_JMP))   target = UAW'(UA_JMP);
        else if (op == OPW'(OPC_BEQ))   target = UAW'(UA_BR);
        else if (op == OPW'(OPC_LOAD) ||
                 op == OPW'(OPC_STORE)) target = UAW'(UA_MADR);
      end
    end else begin : g_mem
      always_comb begin
        target = '0;
        if      (op == OPW'(OPC_LOAD))  target = UAW'(UA_LDRD);
        else if (op == OPW'(OPC_STORE)) target = UAW'(UA_STWR);
      end
    end
  endgenerate

endmodule

// File: rtl/useq_decode.sv
module useq_decode
  import useq_pkg::*;
(
  input  alu_f_e     f_alu,
  input  logic       f_src1,
  input  srcb_f_e    f_src2,
  input  rf_f_e      f_rf,
  input  mem_f_e     f_mem,
  input  pcw_f_e     f_pcw,
  output logic [1:0] alu_op,
  output logic       alu_a_sel,
  output logic [1:0] alu_b_sel,
  output logic       rf_we,
  output logic       rf_dst_rd,
  output logic       rf_wdata_mem,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       mem_addr_data,
  output logic       ir_we,
  output logic       pc_we,
  output logic       pc_we_zero,
  output logic [1:0] pc_src
);

  assign alu_op    = f_alu;
  assign alu_a_sel = f_src1;
  assign alu_b_sel = f_src2;

  always_comb begin
    rf_we        = 1'b0;
    rf_dst_rd    = 1'b0;
    rf_wdata_mem = 1'b0;
    case (f_rf)
      RF_WRALU: begin
        rf_we     = 1'b1;
        rf_dst_rd = 1'b1;
      end
      RF_WRMDR: begin
        rf_we        = 1'b1;
        rf_wdata_mem = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    mem_rd        = 1'b0;
    mem_wr        = 1'b0;
    mem_addr_data = 1'b0;
    ir_we         = 1'b0;
    case (f_mem)
      MF_RDPC: begin
        mem_rd = 1'b1;
        ir_we  = 1'b1;
      end
      MF_RDALU: begin
        mem_rd        = 1'b1;
        mem_addr_data = 1'b1;
      end
      MF_WRALU: begin
        mem_wr        = 1'b1;
        mem_addr_data = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    pc_we      = 1'b0;
    pc_we_zero = 1'b0;
    pc_src     = 2'b00;
    case (f_pcw)
      PF_ALU:  pc_we = 1'b1;
      PF_COND: begin
        pc_we_zero = 1'b1;
        pc_src     = 2'b01;
      end
      PF_JMP: begin
        pc_we  = 1'b1;
        pc_src = 2'b10;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import useq_pkg::*;
#(
  parameter int OPW = 6,
  parameter int UAW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  output logic [UAW-1:0] uaddr,
  output logic [1:0]     alu_op,
  output logic           alu_a_sel,
  output logic [1:0]     alu_b_sel,
  output logic           rf_we,
  output logic           rf_dst_rd,
  output logic           rf_wdata_mem,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           mem_addr_data,
  output logic           ir_we,
  output logic           pc_we,
  output logic           pc_we_zero,
  output logic [1:0]     pc_src
);

  localparam logic [UAW-1:0] UA_ONE = UAW'(1);

  uword_t         cur;
  logic [UAW-1:0] tgt1, tgt2, nxt;

  useq_rom #(.UAW(UAW)) u_rom (
    .addr (uaddr),
    .word (cur)
  );

  useq_dispatch #(.OPW(OPW), .UAW(UAW), .TBL(1)) u_disp1 (
    .op     (opcode),
    .target (tgt1)
  );

  useq_dispatch #(.OPW(OPW), .UAW(UAW), .TBL(2)) u_disp2 (
    .op     (opcode),
    .target (tgt2)
  );

  useq_decode u_dec (
    .f_alu         (cur.alu),
    .f_src1        (cur.src1),
    .f_src2        (cur.src2),
    .f_rf          (cur.rfc),
    .f_mem         (cur.mem),
    .f_pcw         (cur.pcw),
    .alu_op        (alu_op),
    .alu_a_sel     (alu_a_sel),
    .alu_b_sel     (alu_b_sel),
    .rf_we         (rf_we),
    .rf_dst_rd     (rf_dst_rd),
    .rf_wdata_mem  (rf_wdata_mem),
    .mem_rd        (mem_rd),
    .mem_wr        (mem_wr),
    .mem_addr_data (mem_addr_data),
    .ir_we         (ir_we),
    .pc_we         (pc_we),
    .pc_we_zero    (pc_we_zero),
    .pc_src        (pc_src)
  );

  always_comb begin
    case (cur.seq)
      SQ_FETCH: nxt = '0;
      SQ_DISP1: nxt = tgt1;
      SQ_DISP2: nxt = tgt2;
      default:  nxt = uaddr + UA_ONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) uaddr <= '0;
    else     uaddr <= nxt;
  end

  // R3
  fetch_ctl_chk: assert property (@(posedge clk) disable iff (rst)
    (uaddr == '0) |-> (ir_we && pc_we && mem_rd && !mem_addr_data));

  // R2
  fetch_step_chk: assert property (@(posedge clk) disable iff (rst)
    (uaddr == '0) |=> (uaddr == UA_ONE));

  // R2
  wb_return_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> (uaddr == '0));

  // R10
  br_cond_chk: assert property (@(posedge clk) disable iff (rst)
    pc_we_zero |-> (alu_op == 2'b01 && pc_src == 2'b01));

  // R13
  mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R13
  pc_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pc_we && pc_we_zero));

endmodule

// File: tb/sim_ucode_sequencer.sv
module sim_ucode_sequencer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = '0;
  logic [3:0] uaddr;
  logic [1:0] alu_op, alu_b_sel, pc_src;
  logic       alu_a_sel, rf_we, rf_dst_rd, rf_wdata_mem;
  logic       mem_rd, mem_wr, mem_addr_data, ir_we, pc_we, pc_we_zero;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  ucode_sequencer u0 (
    .clk (clk), .rst (rst), .opcode (opcode), .uaddr (uaddr),
    .alu_op (alu_op), .alu_a_sel (alu_a_sel), .alu_b_sel (alu_b_sel),
    .rf_we (rf_we), .rf_dst_rd (rf_dst_rd), .rf_wdata_mem (rf_wdata_mem),
    .mem_rd (mem_rd), .mem_wr (mem_wr), .mem_addr_data (mem_addr_data),
    .ir_we (ir_we), .pc_we (pc_we), .pc_we_zero (pc_we_zero), .pc_src (pc_src)
  );

  // packed view: alu_op a b rf_we dst wmem mrd mwr iord irwe pcwe pcwz pcsrc
  function automatic logic [15:0] got_ctl();
    return {alu_op, alu_a_sel, alu_b_sel, rf_we, rf_dst_rd, rf_wdata_mem,
            mem_rd, mem_wr, mem_addr_data, ir_we, pc_we, pc_we_zero, pc_src};
  endfunction

  function automatic logic [15:0] exp_ctl(input int u);
    logic [15:0] v = '0;
    case (u)
      0: begin v[12:11] = 2'b01; v[7] = 1; v[4] = 1; v[3] = 1; end
      1: v[12:11] = 2'b11;
      2: begin v[13] = 1; v[12:11] = 2'b10; end
      3: begin v[7] = 1; v[5] = 1; end
      4: begin v[10] = 1; v[8] = 1; end
      5: begin v[6] = 1; v[5] = 1; end
      6: begin v[15:14] = 2'b10; v[13] = 1; end
      7: begin v[10] = 1; v[9] = 1; end
      8: begin v[15:14] = 2'b01; v[13] = 1; v[2] = 1; v[1:0] = 2'b01; end
      9: begin v[3] = 1; v[1:0] = 2'b10; end
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic string ctl_tag(input int u);
    case (u)
      0: return "R3";
      1: return "R4 R12";
      2: return "R5 R12";
      3, 4: return "R7 R12";
      5: return "R8 R12";
      6, 7: return "R9 R12";
      8: return "R10 R12";
      9: return "R11 R12";
      default: return "R12";
    endcase
  endfunction

  function automatic int tbl1(input logic [5:0] op);
    case (op)
      6'b000000: return 6;
      6'b000010: return 9;
      6'b000100: return 8;
      6'b100011, 6'b101011: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic int tbl2(input logic [5:0] op);
    case (op)
      6'b100011: return 3;
      6'b101011: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic int next_ua(input int u, input logic [5:0] op);
    case (u)
      0, 3, 6: return u + 1;
      1: return tbl1(op);
      2: return tbl2(op);
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_state(input int u);
    chk((u == 0) ? "R1 R2" : "R2 R4 R5 R6", 16'(uaddr), 16'(u));
    chk(ctl_tag(u), got_ctl(), exp_ctl(u));
    chk("R13", 16'((mem_rd && mem_wr) || (pc_we && pc_we_zero)), 16'd0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int u;
    // sweep every opcode through one full instruction
    for (int op = 0; op < 64; op++) begin
      opcode = 6'(op);
      do_reset();
      u = 0;
      check_state(u);
      for (int step = 0; step < 6; step++) begin
        @(negedge clk);
        u = next_ua(u, opcode);
        check_state(u);
        if (u == 0) break;
      end
    end

    // R5: table 2 uses the opcode present at its own dispatch cycle
    opcode = 6'b100011;
    do_reset();
    @(negedge clk);
    @(negedge clk);
    chk("R5", 16'(uaddr), 16'd2);
    opcode = 6'b101011;
    @(negedge clk);
    chk("R5", 16'(uaddr), 16'd5);
    chk("R8", got_ctl(), exp_ctl(5));
    opcode = 6'b000010;
    @(negedge clk);
    chk("R2", 16'(uaddr), 16'd0);

    // R1: reset in the middle of an R-type instruction
    opcode = 6'b000000;
    do_reset();
    repeat (3) @(negedge clk);
    chk("R9", 16'(uaddr), 16'd7);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", 16'(uaddr), 16'd0);
    chk("R1", got_ctl(), exp_ctl(0));
    rst = 1'b0;
    @(negedge clk);
    chk("R2", 16'(uaddr), 16'd1);

    summary();
    $finish;
  end

endmodule